// File: doc/BRIEF.md
# Bus Target Stop and Disconnect Controller

This block is the target side of a PCI-style parallel bus at the point where a transaction in progress must be cut short. After an external address decoder claims a transaction, the block drives DEVSEL# and paces TRDY# from a backend data-ready flag. When the backend raises a stop request during the data phases, the block asserts STOP#. It then handles TRDY# so that the initiator sees one of three endings: a retry with no word moved, a disconnect that moves a word in the same clock as STOP#, or a disconnect that holds a pending TRDY# until the initiator supplies IRDY#.

The ending is classified in the first clock that STOP# is driven. TRDY# deasserted in that clock gives a retry. TRDY# and IRDY# both asserted gives disconnect B. TRDY# asserted while IRDY# is deasserted gives disconnect A. STOP# remains driven until FRAME# is sampled deasserted. On the next clock the block releases all three target signals and reports the ending on a one-clock code output. A transfer strobe marks every clock edge at which a data word moves.

Top module: `tgt_stop_ctl`

## Requirements
- R1: In idle, a sampled claim with FRAME# low asserts DEVSEL# in the next clock, and TRDY# in that clock follows the ready flag sampled with the claim.
- R2: A transaction that ends without STOP# ends at the edge where FRAME# is high and a word transfers (or IRDY# is high), and reports code 2'b00.
- R3: A stop request sampled in a data phase asserts STOP# in the next clock, and STOP# stays asserted at every edge where FRAME# is sampled low.
- R4: If TRDY# is deasserted in the first STOP# clock, no word transfers for the rest of the transaction and the code is 2'b01 (retry).
- R5: If TRDY# is asserted and IRDY# deasserted in the first STOP# clock, TRDY# stays asserted until IRDY# is sampled asserted and that word transfers, and the code is 2'b10 (disconnect A).
- R6: If TRDY# and IRDY# are both asserted in the first STOP# clock, that word transfers and the code is 2'b11 (disconnect B).
- R7: While STOP# is asserted, TRDY# is never newly asserted; once it is seen deasserted it stays deasserted until the transaction ends.
- R8: In the clock after the ending edge, DEVSEL#, TRDY# and STOP# are all deasserted (high).
- R9: The termination valid output is high for exactly one clock per transaction, in the clock after the ending edge, with the code valid in that clock.
- R10: The transfer strobe is high in exactly those clocks where IRDY# and TRDY# are both asserted, so the count of strobes per transaction equals the words moved.
- R11: A stop request while the block is idle, or while another target owns the bus, has no effect: STOP# and DEVSEL# stay high.
- R12: Before STOP#, a TRDY# that is asserted while IRDY# is high and FRAME# low stays asserted until the word transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_n_i | input | 1 | FRAME# from the initiator, active low |
| irdy_n_i | input | 1 | IRDY# from the initiator, active low |
| claim_i | input | 1 | Address decoder hit for the current address phase |
| stop_req_i | input | 1 | Backend request to end the transaction |
| ready_i | input | 1 | Backend can move a word in the next clock |
| devsel_n_o | output | 1 | DEVSEL#, active low |
| trdy_n_o | output | 1 | TRDY#, active low |
| stop_n_o | output | 1 | STOP#, active low |
| xfer_o | output | 1 | High in a clock where a data word moves |
| term_vld_o | output | 1 | One-clock pulse when the transaction has ended |
| term_code_o | output | 2 | 00 normal, 01 retry, 10 disconnect A, 11 disconnect B |

## Verification
The bench runs each ending type and drives the initiator reactively. FRAME# rises only after STOP# is seen, and the bench inserts IRDY# wait states so that disconnect A really waits. A design that classifies the ending one clock late would call a disconnect B case a disconnect A case, and would miscount the words. A retry case where the backend becomes ready after STOP# would expose a design that lets TRDY# assert again and moves a stray word. A lingering FRAME# exposes a STOP# released too early, and an idle stop request exposes a design that asserts STOP# without owning the bus.

// File: rtl/tgt_stop_pkg.sv
package tgt_stop_pkg;
  localparam int unsigned TERM_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_STOP1 = 2'd2,  // first clock with STOP# driven
    ST_STOPW = 2'd3   // STOP# held, waiting for FRAME# high
  } tgt_st_e;

  typedef enum logic [TERM_W-1:0] {
    TERM_NORMAL = 2'b00,
    TERM_RETRY  = 2'b01,
    TERM_DISC_A = 2'b10,
    TERM_DISC_B = 2'b11
  } term_e;
endpackage

// File: rtl/tgt_stop_fsm.sv
module tgt_stop_fsm
  import tgt_stop_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    frame_n_i,
  input  logic    irdy_n_i,
  input  logic    claim_i,
  input  logic    stop_req_i,
  input  logic    xfer_i,
  output tgt_st_e state_o,
  output logic    start_o,
  output logic    done_o,
  output logic    devsel_o,
  output logic    stop_o
);
  tgt_st_e state_q, state_d;

  assign start_o = (state_q == ST_IDLE) && claim_i && !frame_n_i;

  always_comb begin
    unique case (state_q)
      ST_DATA:            done_o = frame_n_i && (xfer_i || irdy_n_i);
      ST_STOP1, ST_STOPW: done_o = frame_n_i;
      default:            done_o = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_o) state_d = ST_DATA;
      ST_DATA:  if (done_o) state_d = ST_IDLE;
                else if (stop_req_i) state_d = ST_STOP1;
      ST_STOP1: state_d = done_o ? ST_IDLE : ST_STOPW;
      ST_STOPW: if (done_o) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign devsel_o = (state_q != ST_IDLE);
  assign stop_o   = (state_q == ST_STOP1) || (state_q == ST_STOPW);
endmodule

// File: rtl/tgt_trdy_ctl.sv
module tgt_trdy_ctl
  import tgt_stop_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  tgt_st_e state_i,
  input  logic    start_i,
  input  logic    done_i,
  input  logic    irdy_n_i,
  input  logic    ready_i,
  output logic    trdy_o,
  output logic    xfer_o
);
  logic trdy_q, trdy_d;
  logic pend;

  assign xfer_o = trdy_q && !irdy_n_i && (state_i != ST_IDLE);
  // asserted TRDY# must be held until its word moves
  assign pend   = trdy_q && !xfer_o;

  always_comb begin
    trdy_d = 1'b0;
    unique case (state_i)
      ST_IDLE:            trdy_d = start_i && ready_i;
      ST_DATA:            trdy_d = !done_i && (pend || ready_i);
      ST_STOP1, ST_STOPW: trdy_d = !done_i && pend;  // never re-asserted
      default:            trdy_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trdy_q <= 1'b0;
    else         trdy_q <= trdy_d;
  end

  assign trdy_o = trdy_q;
endmodule

// File: rtl/tgt_term_report.sv
module tgt_term_report
  import tgt_stop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tgt_st_e           state_i,
  input  logic              done_i,
  input  logic              trdy_i,
  input  logic              irdy_n_i,
  output logic              vld_o,
  output logic [TERM_W-1:0] code_o
);
  term_e first_code, lat_q, code_q;
  logic  vld_q;

  always_comb begin
    if (!trdy_i)        first_code = TERM_RETRY;
    else if (!irdy_n_i) first_code = TERM_DISC_B;
    else                first_code = TERM_DISC_A;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      lat_q  <= TERM_NORMAL;
      code_q <= TERM_NORMAL;
    end else begin
      vld_q <= done_i;
      if (state_i == ST_STOP1) lat_q <= first_code;
      if (done_i) begin
        unique case (state_i)
          ST_STOP1: code_q <= first_code;
          ST_STOPW: code_q <= lat_q;
          default:  code_q <= TERM_NORMAL;
        endcase
      end
    end
  end

  assign vld_o  = vld_q;
  assign code_o = code_q;
endmodule

// File: rtl/tgt_stop_ctl.sv
module tgt_stop_ctl
  import tgt_stop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_n_i,
  input  logic              irdy_n_i,
  input  logic              claim_i,
  input  logic              stop_req_i,
  input  logic              ready_i,
  output logic              devsel_n_o,
  output logic              trdy_n_o,
  output logic              stop_n_o,
  output logic              xfer_o,
  output logic              term_vld_o,
  output logic [TERM_W-1:0] term_code_o
);
  tgt_st_e state;
  logic    start, done, devsel, stop, trdy, xfer;

  tgt_stop_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_n_i  (frame_n_i),
    .irdy_n_i   (irdy_n_i),
    .claim_i    (claim_i),
    .stop_req_i (stop_req_i),
    .xfer_i     (xfer),
    .state_o    (state),
    .start_o    (start),
    .done_o     (done),
    .devsel_o   (devsel),
    .stop_o     (stop)
  );

  tgt_trdy_ctl u_trdy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .start_i  (start),
    .done_i   (done),
    .irdy_n_i (irdy_n_i),
    .ready_i  (ready_i),
    .trdy_o   (trdy),
    .xfer_o   (xfer)
  );

  tgt_term_report u_rep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .done_i   (done),
    .trdy_i   (trdy),
    .irdy_n_i (irdy_n_i),
    .vld_o    (term_vld_o),
    .code_o   (term_code_o)
  );

  assign devsel_n_o = !devsel;
  assign trdy_n_o   = !trdy;
  assign stop_n_o   = !stop;
  assign xfer_o     = xfer;
endmodule

// File: rtl/tgt_stop_ctl_chk.sv
module tgt_stop_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_n_i,
  input logic       irdy_n_i,
  input logic       devsel_n_o,
  input logic       trdy_n_o,
  input logic       stop_n_o,
  input logic       xfer_o,
  input logic       term_vld_o
);
  AST_STOP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_n_o && !frame_n_i) |=> !stop_n_o); // R3

  AST_DISC_A_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_n_o && !trdy_n_o && irdy_n_i && !frame_n_i) |=> !trdy_n_o); // R5

  AST_NO_NEW_TRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_n_o && trdy_n_o) |=> trdy_n_o); // R7

  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_n_o && frame_n_i) |=> (devsel_n_o && trdy_n_o && stop_n_o)); // R8

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_vld_o |=> !term_vld_o); // R9

  AST_XFER_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> !devsel_n_o); // R10

  AST_IDLE_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    devsel_n_o |=> stop_n_o); // R11

  AST_TRDY_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_n_o && irdy_n_i && stop_n_o && !frame_n_i) |=> !trdy_n_o); // R12
endmodule

bind tgt_stop_ctl tgt_stop_ctl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_n_i  (frame_n_i),
  .irdy_n_i   (irdy_n_i),
  .devsel_n_o (devsel_n_o),
  .trdy_n_o   (trdy_n_o),
  .stop_n_o   (stop_n_o),
  .xfer_o     (xfer_o),
  .term_vld_o (term_vld_o)
);

// File: tb/tgt_stop_ctl_tb.sv
module tgt_stop_ctl_tb;
  import tgt_stop_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, claim = 1'b0, stop_req = 1'b0, ready = 1'b0;
  logic devsel_n, trdy_n, stop_n, xfer, term_vld;
  logic [TERM_W-1:0] term_code;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  typedef struct { logic [1:0] code; int nx; } exp_t;
  exp_t exp_q[$];
  int mon_x = 0;

  always #2.5 clk = ~clk;

  tgt_stop_ctl u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .frame_n_i (frame_n), .irdy_n_i (irdy_n), .claim_i (claim),
    .stop_req_i (stop_req), .ready_i (ready),
    .devsel_n_o (devsel_n), .trdy_n_o (trdy_n), .stop_n_o (stop_n),
    .xfer_o (xfer), .term_vld_o (term_vld), .term_code_o (term_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: words per transaction and ending code
  always @(negedge clk) begin
    if (rst_n) begin
      if (xfer) mon_x++;
      if (term_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected end pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(term_code == e.code, "R2/R4/R5/R6 code", int'(term_code), int'(e.code));
          chk(mon_x == e.nx, "R10 words moved", mon_x, e.nx);
        end
        mon_x = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // reactive initiator, one transaction
  task automatic run_txn(input int n, input int stop_cyc, input logic [15:0] rdy_m,
                         input logic [15:0] wait_m, input int linger,
                         input logic [1:0] exp_code, input int exp_x);
    exp_t e;
    int  remaining = n;
    bit  stop_seen = 1'b0, fin = 1'b0, trdy_dead = 1'b0, hold_prev = 1'b0;
    int  lcnt = 0;
    e.code = exp_code; e.nx = exp_x;
    exp_q.push_back(e);
    @(posedge clk); #1;
    frame_n = 1'b0; claim = 1'b1; irdy_n = 1'b1; ready = rdy_m[0]; stop_req = 1'b0;
    for (int cyc = 0; cyc < 64; cyc++) begin
      @(posedge clk); #1;
      claim = 1'b0;
      if (!fin) irdy_n = (cyc < 16) ? wait_m[cyc] : 1'b0;
      if (!fin && !irdy_n &&
          ((stop_seen && lcnt >= linger) || (!stop_seen && remaining == 1))) fin = 1'b1;
      frame_n  = fin;
      if (stop_seen) lcnt++;
      ready    = (cyc < 15) ? rdy_m[cyc+1] : 1'b1;
      stop_req = (cyc == stop_cyc);
      @(negedge clk);
      if (cyc == 0) chk(!devsel_n, "R1 devsel after claim", devsel_n, 0);
      if (cyc == 0) chk(trdy_n == !rdy_m[0], "R1 first trdy", trdy_n, !rdy_m[0]);
      if (hold_prev) chk(!trdy_n, "R12/R5 trdy held until word", trdy_n, 0);
      if (stop_seen) chk(!stop_n, "R3 stop held while frame low", stop_n, 0);
      if (trdy_dead) chk(trdy_n, "R7 trdy stays off after stop", trdy_n, 1);
      if (xfer) remaining--;
      if (!stop_n) begin
        if (!stop_seen && trdy_n) trdy_dead = 1'b1;
        if (stop_seen && trdy_n) trdy_dead = 1'b1;
        stop_seen = 1'b1;
      end
      hold_prev = !trdy_n && irdy_n && !frame_n;
      if (frame_n && (irdy_n || !trdy_n || !stop_n)) break;
    end
    @(posedge clk); #1;
    frame_n = 1'b1; irdy_n = 1'b1; stop_req = 1'b0; ready = 1'b0;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n, "R8 signals released",
        {devsel_n, trdy_n, stop_n}, 3'b111);
    @(negedge clk);
    chk(!term_vld, "R9 end pulse one clock", term_vld, 0);
  endtask

  initial begin
    #1;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !xfer && !term_vld, "R8 reset state",
        {devsel_n, trdy_n, stop_n, xfer, term_vld}, 5'b11100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: plain burst, backend always ready
    run_txn(3, -1, 16'hFFFF, 16'h0000, 0, TERM_NORMAL, 3);
    // R12: backend wait states and initiator wait states
    run_txn(3, -1, 16'hFFFA, 16'h0006, 0, TERM_NORMAL, 3);
    // R4: retry, backend ready only after STOP#, FRAME# lingers
    run_txn(4, 0, 16'hFFF8, 16'h0000, 3, TERM_RETRY, 0);
    // R4: plain retry
    run_txn(4, 0, 16'h0000, 16'h0000, 0, TERM_RETRY, 0);
    // R6: disconnect B on first data phase
    run_txn(4, 0, 16'hFFFF, 16'h0000, 0, TERM_DISC_B, 2);
    // R6: disconnect B after several words
    run_txn(6, 2, 16'hFFFF, 16'h0000, 0, TERM_DISC_B, 4);
    // R5: disconnect A, IRDY# held off for four clocks
    run_txn(4, 0, 16'hFFFF, 16'h000F, 0, TERM_DISC_A, 1);

    // R11: stop request while idle and while another target owns the bus
    @(posedge clk); #1;
    stop_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(stop_n && devsel_n, "R11 idle stop ignored", {stop_n, devsel_n}, 2'b11);
    end
    @(posedge clk); #1;
    frame_n = 1'b0; irdy_n = 1'b0; claim = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      @(negedge clk);
      chk(stop_n && devsel_n, "R11 foreign bus stop ignored", {stop_n, devsel_n}, 2'b11);
    end
    @(posedge clk); #1;
    frame_n = 1'b1; irdy_n = 1'b1; stop_req = 1'b0;
    repeat (2) @(negedge clk);
    run_txn(2, -1, 16'hFFFF, 16'h0000, 0, TERM_NORMAL, 2);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all endings reported", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule